// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is a byte-level I2C target (slave) controlled through a small register bank. A 7-bit own address is programmed into it. The block watches the bus lines for START and STOP conditions and compares the first byte after a START with that address. On a match it acknowledges the byte and then takes one of two roles. In the first role it receives bytes into a data port. In the second it shifts bytes out of that port. Which role applies depends on the read/write bit the master sent.

Software sees progress through a status register. That register records:
- an address match,
- the transfer direction,
- a received byte,
- a transmitted byte,
- an emptied data port,
- a STOP on the bus,
- a general-call hit.

An interrupt-enable register masks the status bits onto one interrupt line. A sticky control bit makes the target refuse written bytes. During a read, the target stretches SCL while software has not yet refilled the data port.

The bus lines are open-drain. The block samples `sclIn`/`sdaIn` through a synchronizer. It pulls a line low by raising `sclOe` or `sdaOe`.

Top module: `i2cTgt`

## Requirements
- R1: After reset all registers read 0, neither bus line is pulled low and `irq` is low.
- R2: The register map is as follows:
  - offset 0: control. Bit 0 forces NACK, bit 1 enables general call, bit 2 enables the target.
  - offset 1: status.
  - offset 2: interrupt enable.
  - offset 3: own address, bits 6:0.
  - offset 4: data port. A write loads the transmit byte; a read returns the last received byte.
  
  An address byte whose upper 7 bits equal a nonzero own address is acknowledged (SDA held low during the 9th clock) and sets status bit 0. Any other address gets no drive for the rest of that transfer.
- R3: At a match, status bit 5 takes the value of the read/write bit: 1 when the master reads.
- R4: In a write transfer each byte is shifted in MSB first and becomes readable at offset 4. Status bit 1 is set when the byte completes.
- R5: While control bit 0 is set, every written data byte is answered with NACK (SDA released on the 9th clock), and it still sets status bit 1. Address bytes are still acknowledged.
- R6: In a read transfer the data port byte is sent MSB first. Status bit 3 is set when the port content moves into the shifter. Status bit 2 is set on the acknowledge clock of each sent byte.
- R7: If the data port is empty at a read byte boundary, SCL is held low until software writes offset 4. While SCL is held, SDA is not driven.
- R8: A NACK from the master after a sent byte ends the read. SDA stays released until STOP or a new START.
- R9: Every STOP on the bus sets status bit 4 while the target is enabled, including STOPs of transfers to other addresses.
- R10: With control bit 1 set, address 0 is acknowledged and sets status bits 0 and 6. With it clear, address 0 is not acknowledged.
- R11: Writing a status bit with 0 clears it; writing 1 leaves it as it was. A new event in the same cycle wins over the clear.
- R12: `irq` is high exactly when some status bit and the same interrupt-enable bit are both 1.
- R13: With control bit 2 clear, the target drives neither line and records no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational) |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | Pull SCL low |
| sdaOe | output | 1 | Pull SDA low |
| irq | output | 1 | Masked interrupt |

## Verification
The bus lines pass through a two-stage synchronizer and one edge register. A drive change therefore appears about three clocks after the SCL edge that causes it.

The bench master keeps every SCL phase ten clocks long. It samples SDA only at the end of an SCL high phase, so acknowledge bits and data bits are read well after they settle.

Status flags and `rdData` follow one clock after an event or a register write. `irq` follows in the same clock as the status change. The bench reads registers only after the bus phase has completed.

Stretching is checked while the master waits on a held SCL, before software refills the port.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;
  localparam int FLAG_W = 7;
  // status / interrupt-enable bit positions
  localparam int F_ADDR   = 0;
  localparam int F_RXD    = 1;
  localparam int F_TXD    = 2;
  localparam int F_EMPTY  = 3;
  localparam int F_STOP   = 4;
  localparam int F_TXMODE = 5;
  localparam int F_GCALL  = 6;
  // register offsets
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_IEN  = 3'd2;
  localparam logic [2:0] A_OWN  = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic captureRx;
  } dpCmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_RX, S_TX, S_TXACK, S_TXWAIT, S_SKIP
  } tgtState_t;
endpackage

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  input  logic              dataWr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEn,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              sdaNow,
  output logic              txBit,
  output logic              txFull,
  output logic              ownHit,
  output logic              gcHit,
  output logic              rwBit,
  output logic [7:0]        rxData
);
  localparam int BYTE_W = ADDR_W + 1;

  logic [SYNC_STAGES:0] sclQ, sdaQ;
  logic sclNow, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] shiftQ, txData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
    end else begin
      sclQ <= {sclQ[SYNC_STAGES-1:0], sclIn};
      sdaQ <= {sdaQ[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow    = sclQ[SYNC_STAGES-1];
  assign sclPrev   = sclQ[SYNC_STAGES];
  assign sdaNow    = sdaQ[SYNC_STAGES-1];
  assign sdaPrev   = sdaQ[SYNC_STAGES];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      txData <= '0;
      txFull <= 1'b0;
      rxData <= '0;
    end else begin
      if (cmd.loadTx)        shiftQ <= txData;
      else if (cmd.shiftIn)  shiftQ <= {shiftQ[BYTE_W-2:0], sdaNow};
      else if (cmd.shiftOut) shiftQ <= {shiftQ[BYTE_W-2:0], 1'b1};
      if (dataWr) begin
        txData <= wrData;
        txFull <= 1'b1;
      end else if (cmd.loadTx) begin
        txFull <= 1'b0;
      end
      if (cmd.captureRx) rxData <= shiftQ;
    end
  end

  assign txBit  = shiftQ[BYTE_W-1];
  assign rwBit  = shiftQ[0];
  assign ownHit = (shiftQ[BYTE_W-1:1] == ownAddr) && (ownAddr != '0);
  assign gcHit  = gcEn && (shiftQ[BYTE_W-1:1] == '0);
endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ifEn,
  input  logic              forceNack,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaNow,
  input  logic              txBit,
  input  logic              txFull,
  input  logic              ownHit,
  input  logic              gcHit,
  input  logic              rwBit,
  output dpCmd_t            cmd,
  output logic              sdaOe,
  output logic              sclOe,
  output logic [FLAG_W-1:0] flagSet,
  output logic              stmVal
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(BYTE_W - 1);

  tgtState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic ackLow, readMode, masterAck;
  logic byteEnd, addrHit, refill;

  assign byteEnd = sclFall && (bitCnt == LAST_BIT);
  assign addrHit = ownHit || gcHit;
  assign refill  = (state == S_ACK && sclFall && readMode) ||
                   (state == S_TXACK && sclFall && masterAck) ||
                   (state == S_TXWAIT);

  always_comb begin
    cmd.shiftIn   = sclRise && (state == S_ADDR || state == S_RX) && (bitCnt != LAST_BIT);
    cmd.shiftOut  = sclFall && (state == S_TX) && (bitCnt != LAST_FALL);
    cmd.loadTx    = refill && txFull;
    cmd.captureRx = (state == S_RX) && byteEnd;
    flagSet          = '0;
    flagSet[F_ADDR]  = (state == S_ADDR) && byteEnd && addrHit;
    flagSet[F_GCALL] = (state == S_ADDR) && byteEnd && gcHit;
    flagSet[F_RXD]   = cmd.captureRx;
    flagSet[F_TXD]   = (state == S_TXACK) && sclRise;
    flagSet[F_EMPTY] = cmd.loadTx;
    flagSet[F_STOP]  = stopSeen && ifEn;
    stmVal = rwBit;
    sdaOe  = (state == S_ACK && ackLow) || (state == S_TX && !txBit);
    sclOe  = (state == S_TXWAIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      ackLow    <= 1'b0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
    end else if (!ifEn || stopSeen) begin
      state <= S_IDLE;
    end else if (startSeen) begin
      state  <= S_ADDR;
      bitCnt <= '0;
    end else begin
      case (state)
        S_ADDR: begin
          if (sclRise && bitCnt != LAST_BIT) bitCnt <= bitCnt + CNT_W'(1);
          if (byteEnd) begin
            if (addrHit) begin
              state    <= S_ACK;
              ackLow   <= 1'b1;
              readMode <= rwBit;
            end else begin
              state <= S_SKIP;
            end
          end
        end
        S_ACK: if (sclFall) begin
          bitCnt <= '0;
          if (!readMode)   state <= S_RX;
          else if (txFull) state <= S_TX;
          else             state <= S_TXWAIT;
        end
        S_RX: begin
          if (sclRise && bitCnt != LAST_BIT) bitCnt <= bitCnt + CNT_W'(1);
          if (byteEnd) begin
            state  <= S_ACK;
            ackLow <= !forceNack;
          end
        end
        S_TX: if (sclFall) begin
          if (bitCnt == LAST_FALL) state <= S_TXACK;
          else bitCnt <= bitCnt + CNT_W'(1);
        end
        S_TXACK: begin
          if (sclRise) masterAck <= !sdaNow;
          if (sclFall) begin
            bitCnt <= '0;
            if (!masterAck)  state <= S_SKIP;
            else if (txFull) state <= S_TX;
            else             state <= S_TXWAIT;
          end
        end
        S_TXWAIT: if (txFull) begin
          state  <= S_TX;
          bitCnt <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cTgtRegs.sv
module i2cTgtRegs
  import i2cTgtPkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        rxData,
  input  logic [FLAG_W-1:0] flagSet,
  input  logic              stmVal,
  output logic [7:0]        rdData,
  output logic              forceNack,
  output logic              gcEn,
  output logic              ifEn,
  output logic [ADDR_W-1:0] ownAddr,
  output logic              dataWr,
  output logic [FLAG_W-1:0] statusQ,
  output logic [FLAG_W-1:0] ienQ,
  output logic              irq
);
  logic [2:0] ctrlQ;
  logic [FLAG_W-1:0] statusNext;

  always_comb begin
    statusNext = statusQ;
    if (wrEn && regAddr == A_STAT) statusNext = statusNext & wrData[FLAG_W-1:0];
    statusNext = statusNext | flagSet;
    if (flagSet[F_ADDR]) statusNext[F_TXMODE] = stmVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      ienQ    <= '0;
      ownAddr <= '0;
      statusQ <= '0;
    end else begin
      if (wrEn && regAddr == A_CTRL) ctrlQ   <= wrData[2:0];
      if (wrEn && regAddr == A_IEN)  ienQ    <= wrData[FLAG_W-1:0];
      if (wrEn && regAddr == A_OWN)  ownAddr <= wrData[ADDR_W-1:0];
      statusQ <= statusNext;
    end
  end

  always_comb begin
    case (regAddr)
      A_CTRL:  rdData = {5'd0, ctrlQ};
      A_STAT:  rdData = 8'(statusQ);
      A_IEN:   rdData = 8'(ienQ);
      A_OWN:   rdData = 8'(ownAddr);
      A_DATA:  rdData = rxData;
      default: rdData = '0;
    endcase
  end

  assign forceNack = ctrlQ[0];
  assign gcEn      = ctrlQ[1];
  assign ifEn      = ctrlQ[2];
  assign dataWr    = wrEn && (regAddr == A_DATA);
  assign irq       = |(statusQ & ienQ);
endmodule

// File: rtl/i2cTgt.sv
module i2cTgt
  import i2cTgtPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       irq
);
  dpCmd_t dpCmd;
  logic sclRise, sclFall, startSeen, stopSeen, sdaNow, txBit, txFull;
  logic ownHit, gcHit, rwBit, forceNack, gcEn, ifEn, dataWr, stmVal;
  logic [7:0] rxData;
  logic [ADDR_W-1:0] ownAddr;
  logic [FLAG_W-1:0] flagSet, statusQ, ienQ;

  i2cTgtDatapath #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(dpCmd),
    .dataWr(dataWr), .wrData(wrData), .ownAddr(ownAddr), .gcEn(gcEn),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .sdaNow(sdaNow), .txBit(txBit), .txFull(txFull), .ownHit(ownHit), .gcHit(gcHit),
    .rwBit(rwBit), .rxData(rxData)
  );

  i2cTgtControl #(.BYTE_W(ADDR_W + 1)) u_ctl (
    .clk(clk), .rstN(rstN), .ifEn(ifEn), .forceNack(forceNack),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .sdaNow(sdaNow), .txBit(txBit), .txFull(txFull), .ownHit(ownHit), .gcHit(gcHit),
    .rwBit(rwBit), .cmd(dpCmd), .sdaOe(sdaOe), .sclOe(sclOe), .flagSet(flagSet),
    .stmVal(stmVal)
  );

  i2cTgtRegs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rxData(rxData), .flagSet(flagSet), .stmVal(stmVal), .rdData(rdData),
    .forceNack(forceNack), .gcEn(gcEn), .ifEn(ifEn), .ownAddr(ownAddr),
    .dataWr(dataWr), .statusQ(statusQ), .ienQ(ienQ), .irq(irq)
  );
endmodule

// File: rtl/i2cTgtChecker.sv
module i2cTgtChecker (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlEn,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       txFull,
  input logic       loadTx,
  input logic       captureRx,
  input logic [6:0] statusQ,
  input logic [6:0] ienQ,
  input logic       irq
);
  // R13
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> (!sdaOe && !sclOe));
  // R7
  stretch_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && txFull) |=> !sclOe);
  // R7
  stretch_sda_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> !sdaOe);
  // R6
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadTx |=> statusQ[3]);
  // R4
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureRx |=> statusQ[1]);
  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != 7'd0 && ienQ != 7'd0));
endmodule

bind i2cTgt i2cTgtChecker u_chk (
  .clk(clk), .rstN(rstN), .ctrlEn(ifEn), .sclOe(sclOe), .sdaOe(sdaOe),
  .txFull(txFull), .loadTx(dpCmd.loadTx), .captureRx(dpCmd.captureRx),
  .statusQ(statusQ), .ienQ(ienQ), .irq(irq)
);

// File: tb/i2cTgt_bench.sv
`timescale 1ns/1ps
module i2cTgt_bench;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;
  // {addr7, data8, forceNack, expAddrAck, expDataAck}
  localparam int NV = 5;
  localparam logic [17:0] VECS [0:NV-1] = '{
    {7'h5A, 8'hA5, 1'b0, 1'b1, 1'b1},
    {7'h5A, 8'h3C, 1'b1, 1'b1, 1'b0},
    {7'h21, 8'h77, 1'b0, 1'b0, 1'b0},
    {7'h5A, 8'h01, 1'b0, 1'b1, 1'b1},
    {7'h00, 8'h55, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, irq, sclLine, sdaLine;
  int nChecks = 0, nFail = 0, stretchCycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign sclLine = mScl & ~sclOe;
  assign sdaLine = mSda & ~sdaOe;

  i2cTgt u_i2cTgt (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe),
    .sdaOe(sdaOe), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = rdData;
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic clockBit(input logic b, output logic r);
    mSda = b; waitQ(); mScl = 1'b1;
    @(negedge clk);
    while (!sclLine) begin stretchCycles++; @(negedge clk); end
    waitQ(); r = sdaLine; mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clockBit(b[i], r);
    clockBit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic ack);
    logic r;
    b = '0;
    for (int i = 0; i < 8; i++) begin clockBit(1'b1, r); b = {b[6:0], r}; end
    clockBit(~ack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      summary();
    end
  end

  initial begin
    logic [7:0] d, b;
    logic ack, r;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regRead(3'd0, d); check("R1 ctrl", d, 0);
    regRead(3'd1, d); check("R1 status", d, 0);
    regRead(3'd3, d); check("R1 own", d, 0);
    check("R1 drive", {sclOe, sdaOe}, 0);
    check("R1 irq", irq, 0);

    regWrite(3'd3, {1'b0, OWN});
    // vector table: write transfers (R2 R4 R5 R9 R10)
    for (int v = 0; v < NV; v++) begin
      regWrite(3'd0, {5'd0, 1'b1, 1'b0, VECS[v][2]});
      regWrite(3'd1, 8'h00);
      busStart();
      sendByte({VECS[v][17:11], 1'b0}, ack);
      check($sformatf("R2 addr ack v%0d", v), ack, VECS[v][1]);
      sendByte(VECS[v][10:3], ack);
      check($sformatf("R5 data ack v%0d", v), ack, VECS[v][0]);
      busStop();
      regRead(3'd1, d);
      check($sformatf("R9 R4 status v%0d", v), d, VECS[v][1] ? 8'h13 : 8'h10);
      if (VECS[v][1]) begin
        regRead(3'd4, d);
        check($sformatf("R4 rx data v%0d", v), d, VECS[v][10:3]);
      end
    end

    // read transfer: R3 R6 R7 R8
    regWrite(3'd0, 8'h04);
    regWrite(3'd1, 8'h00);
    regWrite(3'd4, 8'hC3);
    busStart();
    sendByte({OWN, 1'b1}, ack);
    check("R2 read addr ack", ack, 1);
    regRead(3'd1, d);
    check("R3 R6 status after addr", d, 8'h29);
    regWrite(3'd1, 8'h00);
    recvByte(b, 1'b1);
    check("R6 first byte", b, 8'hC3);
    regRead(3'd1, d);
    check("R6 sent flag", d, 8'h04);
    stretchCycles = 0;
    fork
      recvByte(b, 1'b0);
      begin
        repeat (60) @(negedge clk);
        check("R7 scl held", sclOe, 1);
        check("R7 sda free", sdaOe, 0);
        regWrite(3'd4, 8'h96);
      end
    join
    check("R7 second byte", b, 8'h96);
    check("R7 stretched", stretchCycles > 20, 1);
    repeat (5) @(negedge clk);
    check("R8 sda released", sdaOe, 0);
    clockBit(1'b1, r);
    check("R8 no drive on extra clock", r, 1);
    busStop();
    regRead(3'd1, d);
    check("R6 status end", d, 8'h1C);

    // R11 write-zero-to-clear
    regWrite(3'd1, 8'hFF);
    regRead(3'd1, d); check("R11 ones keep", d, 8'h1C);
    regWrite(3'd1, 8'hEF);
    regRead(3'd1, d); check("R11 zero clears", d, 8'h0C);
    // R12 interrupt masking
    regWrite(3'd2, 8'h04);
    @(negedge clk); check("R12 irq on", irq, 1);
    regWrite(3'd2, 8'h10);
    @(negedge clk); check("R12 irq masked", irq, 0);
    regWrite(3'd2, 8'h00);

    // R10 general call
    regWrite(3'd0, 8'h06);
    regWrite(3'd1, 8'h00);
    busStart();
    sendByte(8'h00, ack);
    check("R10 gc ack", ack, 1);
    busStop();
    regRead(3'd1, d); check("R10 gc status", d, 8'h51);

    // R13 disabled
    regWrite(3'd0, 8'h00);
    regWrite(3'd1, 8'h00);
    busStart();
    sendByte({OWN, 1'b0}, ack);
    check("R13 no ack", ack, 0);
    busStop();
    regRead(3'd1, d); check("R13 no flags", d, 0);

    finished = 1'b1;
    summary();
  end
endmodule